// File: doc/BRIEF.md
# I2C Register Slave with Timekeeping Snapshot Freeze

This block is the two-wire serial front end of a 64-byte register space. The lowest eight bytes are user-visible copies of a 64-bit timekeeping value supplied by a counter outside the block. The other 56 bytes are general-purpose storage. A bus master addresses the block by its 7-bit device address. It loads an internal byte pointer with a word address, then writes or reads consecutive bytes. The pointer advances by itself after each acknowledged byte.

On each update strobe, the timekeeping value is copied into the eight clock bytes, so a read returns a recent time. While a transaction that targets this block has its pointer inside the clock range, the copy is held off. A multi-byte read of the time therefore sees one coherent snapshot. A strobe that arrives during the hold is remembered. The copy is applied as soon as the pointer leaves the clock range or the master issues STOP. A bus write into the clock range is also forwarded on a one-cycle time-set port, so the external counter can be loaded.

SCL and SDA are sampled on the system clock. The open-drain SDA pin is modelled as an input, a constant-low output and an output enable.

Top module: `i2c_rtc_regslave`

## Requirements
- R1: The device address is 1101000 (first byte D0h for a write, D1h for a read). On a match, the slave pulls SDA low in the acknowledge slot. On any other address, it never enables its SDA driver until the next START, and the bus transaction has no effect. After reset, SDA is released.
- R2: In a write, the first byte after the device address is acknowledged, and its low six bits load the pointer.
- R3: Each further byte written is acknowledged and stored at the pointer. The pointer then increments and wraps from 3Fh to 00h. All 64 bytes read 00h after reset.
- R4: A read (device address with R/W=1, usually after a repeated START that follows the word address) returns the byte at the pointer, MSB first. SDA is changed only while SCL is low.
- R5: In a sequential read, the pointer increments only when the master acknowledges a byte. A NACK ends transmission, and the pointer keeps the address of the byte just sent.
- R6: A read that begins without a word address (current-address read) starts at the pointer left by the previous transaction.
- R7: Clock byte i (address i, 0 to 7) holds bits 8i+7 down to 8i of the time input. On an update strobe while no freeze is active, all eight bytes take the time input on the next clock.
- R8: A freeze is active from a device-address match until STOP, whenever the pointer is 00h to 07h, in both read and write transactions. While it is active, no update strobe changes the clock bytes.
- R9: A strobe that arrives during a freeze is applied, using the time input present at that point, on the first clock after the freeze ends. A freeze ends at STOP or when the pointer moves outside 00h to 07h.
- R10: A bus write to address 00h to 07h produces a one-clock time-set pulse. The pulse carries the 3-bit byte address and the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_o | output | 1 | Data driven when enabled (always 0, open drain) |
| sda_oe | output | 1 | High pulls SDA low |
| time_val | input | 64 | Current time from the external counter |
| time_tick | input | 1 | One-clock update strobe for time_val |
| tset_valid | output | 1 | Pulse: a clock byte was written over the bus |
| tset_addr | output | 3 | Clock byte address of that write |
| tset_data | output | 8 | Data of that write |

## Verification
A change on SCL reaches the control logic after two synchronizer flops and an edge register. The slave therefore moves SDA three system clocks after each SCL fall. The bench keeps SCL low for four clocks before every rise, and samples SDA in the middle of the high phase, so an acknowledge or data bit is always settled when it is read.

A time strobe lands in the clock bytes one clock later. A time-set pulse follows one clock after the acknowledge slot begins. The bench observes both through later bus reads, or through a monitor that counts pulses, hundreds of clocks after the event. No result is sampled on an edge where it is still moving.

// File: rtl/i2c_rtc_pkg.sv
// Shared types for the I2C timekeeping register slave.
// Assumes: nothing beyond SystemVerilog-2017.
package i2c_rtc_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,    // no transaction for this slave
        ST_DEV,     // shifting in device address + R/W
        ST_ACKDEV,  // driving acknowledge for device address
        ST_RX,      // shifting in word address or data
        ST_ACKRX,   // driving acknowledge for received byte
        ST_TX,      // shifting out a data byte
        ST_RACK,    // sampling master acknowledge
        ST_WAIT     // released, waiting for START or STOP
    } bus_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the system clock domain and flags bus events.
// Assumes: the system clock is several times faster than SCL, and the
// bus idles high (so reset loads ones).
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
    logic                   scl_prev, sda_prev;

    // synchronizer chains for both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
        end
    end

    // previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[SYNC_STAGES-1];
            sda_prev <= sda_chain[SYNC_STAGES-1];
        end
    end

    // bus events decoded from current and previous levels
    always_comb begin
        scl_lvl   = scl_chain[SYNC_STAGES-1];
        sda_lvl   = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
// Byte-level protocol engine: matches the device address, loads the pointer,
// issues write strobes, shifts read data out and advances the pointer on ACK.
// Assumes: event inputs come from i2c_line_sync; rd_data reflects the store
// at the current pointer without delay.
module i2c_slave_fsm
    import i2c_rtc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              busy,
    output logic              sda_oe
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] LAST_TX_BIT   = 4'd7;

    bus_state_t        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sr;
    logic              first_rx;
    logic              ack_q;

    // protocol sequencing, pointer and SDA driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sr       <= '0;
            ptr      <= '0;
            busy     <= 1'b0;
            sda_oe   <= 1'b0;
            first_rx <= 1'b0;
            ack_q    <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                busy   <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT: ;
                    ST_DEV: begin
                        if (scl_rise && cnt < BITS_PER_BYTE) begin
                            sr  <= {sr[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == BITS_PER_BYTE) begin
                            if (sr[BYTE_W-1:1] == DEV_ADDR) begin
                                state  <= ST_ACKDEV;
                                sda_oe <= 1'b1;
                                busy   <= 1'b1;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_ACKDEV: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (sr[0]) begin
                                state  <= ST_TX;
                                sr     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                state    <= ST_RX;
                                sda_oe   <= 1'b0;
                                first_rx <= 1'b1;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise && cnt < BITS_PER_BYTE) begin
                            sr  <= {sr[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == BITS_PER_BYTE) begin
                            state  <= ST_ACKRX;
                            sda_oe <= 1'b1;
                            if (first_rx) begin
                                ptr <= sr[ADDR_W-1:0];
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sr;
                            end
                        end
                    end
                    ST_ACKRX: begin
                        if (scl_fall) begin
                            state    <= ST_RX;
                            sda_oe   <= 1'b0;
                            cnt      <= '0;
                            first_rx <= 1'b0;
                            if (!first_rx) ptr <= ptr + 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST_TX_BIT) begin
                                state  <= ST_RACK;
                                sda_oe <= 1'b0;
                            end else begin
                                sr     <= {sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sr[BYTE_W-2];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            ack_q <= ~sda_lvl;
                            if (!sda_lvl) ptr <= ptr + 1'b1;
                        end else if (scl_fall) begin
                            if (ack_q) begin
                                state  <= ST_TX;
                                sr     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                cnt    <= '0;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R4
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && !scl_rise) |=> $stable(sda_oe));

    // R5
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> ($past(state) inside {ST_RX, ST_ACKRX, ST_RACK}));

    // R1
    busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == ST_DEV));

endmodule

// File: rtl/rtc_reg_store.sv
// 64-byte register store. The low bytes mirror the external time value,
// with freeze, deferred update and time-set forwarding.
// Assumes: one bus write per clock at most, and an update strobe one clock wide.
module rtc_reg_store
    import i2c_rtc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int CLK_BYTES = 8,
    parameter int TIME_W    = CLK_BYTES * BYTE_W,
    parameter int SEL_W     = $clog2(CLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic [TIME_W-1:0] time_val,
    input  logic              time_tick,
    output logic [BYTE_W-1:0] rd_data,
    output logic              tset_valid,
    output logic [SEL_W-1:0]  tset_addr,
    output logic [BYTE_W-1:0] tset_data
);
    localparam int                DEPTH   = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] CLK_LIM = ADDR_W'(CLK_BYTES);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [TIME_W-1:0] clk_vec;
    logic              freeze, pending, copy_now;

    // freeze and copy decisions
    always_comb begin
        freeze   = busy && (rd_addr < CLK_LIM);
        copy_now = (time_tick || pending) && !freeze;
        rd_data  = mem[rd_addr];
    end

    // remember a strobe that arrived during a freeze
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending <= 1'b0;
        else if (time_tick && freeze) pending <= 1'b1;
        else if (copy_now)           pending <= 1'b0;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        if (i < CLK_BYTES) begin : g_clk
            // clock byte: bus write wins over a snapshot copy
            always_ff @(posedge clk) begin
                if (!rst_n)                                mem[i] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))   mem[i] <= wr_data;
                else if (copy_now)                         mem[i] <= time_val[i*BYTE_W +: BYTE_W];
            end
            assign clk_vec[i*BYTE_W +: BYTE_W] = mem[i];
        end else begin : g_ram
            // plain storage byte
            always_ff @(posedge clk) begin
                if (!rst_n)                              mem[i] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i)) mem[i] <= wr_data;
            end
        end
    end

    // forward bus writes into the clock range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tset_valid <= 1'b0;
            tset_addr  <= '0;
            tset_data  <= '0;
        end else begin
            tset_valid <= wr_en && (wr_addr < CLK_LIM);
            if (wr_en && (wr_addr < CLK_LIM)) begin
                tset_addr <= wr_addr[SEL_W-1:0];
                tset_data <= wr_data;
            end
        end
    end

    // R7
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_tick && !freeze && !wr_en) |=> (clk_vec == $past(time_val)));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_en) |=> $stable(clk_vec));

    // R10
    tset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tset_valid |=> !tset_valid);

endmodule

// File: rtl/i2c_rtc_regslave.sv
// Top level: I2C register slave with a frozen time snapshot in the low bytes.
// Assumes: open-drain SDA is built outside from sda_o/sda_oe; system clock
// at least eight times the SCL rate.
module i2c_rtc_regslave #(
    parameter logic [6:0] DEV_ADDR  = 7'h68,
    parameter int         ADDR_W    = 6,
    parameter int         CLK_BYTES = 8,
    localparam int        TIME_W    = CLK_BYTES * 8,
    localparam int        SEL_W     = $clog2(CLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic [TIME_W-1:0] time_val,
    input  logic              time_tick,
    output logic              tset_valid,
    output logic [SEL_W-1:0]  tset_addr,
    output logic [7:0]        tset_data
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, busy;
    logic [ADDR_W-1:0] wr_addr, ptr;
    logic [7:0]        wr_data, rd_data;

    assign sda_o = 1'b0;

    i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr), .busy(busy),
        .sda_oe(sda_oe)
    );

    rtc_reg_store #(.ADDR_W(ADDR_W), .CLK_BYTES(CLK_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .busy(busy), .time_val(time_val),
        .time_tick(time_tick), .rd_data(rd_data), .tset_valid(tset_valid),
        .tset_addr(tset_addr), .tset_data(tset_data)
    );

endmodule

// File: tb/i2c_rtc_regslave_test.sv
// Self-checking bench: bit-banged bus master, vector table, then directed cases.
module i2c_rtc_regslave_test;
    localparam int Q = 4;
    localparam int H = 8;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_o, sda_oe, tset_valid;
    logic [2:0]  tset_addr;
    logic [7:0]  tset_data;
    logic [63:0] time_val = '0;
    logic        time_tick = 1'b0;
    wire         bus_sda = m_sda & ~sda_oe;

    int n_cmp = 0, n_bad = 0, tset_cnt = 0;
    logic [2:0] tset_last_a;
    logic [7:0] tset_last_d;
    logic       oe_seen = 1'b0, done = 1'b0, ackb;
    logic [7:0] rbuf [8];
    logic [7:0] wbuf [4];

    // {word address, data}
    localparam logic [13:0] VEC [6] = '{
        {6'h08, 8'hA5}, {6'h3F, 8'h5A}, {6'h20, 8'h01},
        {6'h05, 8'hC3}, {6'h15, 8'hFF}, {6'h3E, 8'h00}
    };

    always #10 clk = ~clk;

    i2c_rtc_regslave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_o(sda_o), .sda_oe(sda_oe), .time_val(time_val),
        .time_tick(time_tick), .tset_valid(tset_valid),
        .tset_addr(tset_addr), .tset_data(tset_data)
    );

    always @(posedge clk) begin
        if (tset_valid) begin
            tset_cnt    <= tset_cnt + 1;
            tset_last_a <= tset_addr;
            tset_last_d <= tset_data;
        end
        if (sda_oe) oe_seen <= 1'b1;
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; w(Q); m_scl = 1'b1; w(H); m_scl = 1'b0; w(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; w(Q); m_scl = 1'b1; w(H/2); b = bus_sda; w(H/2); m_scl = 1'b0; w(Q);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; w(Q); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0; w(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; w(Q); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_in(b[i]);
        bit_out(~mack);
        m_sda = 1'b1;
    endtask

    task automatic write_seq(input logic [5:0] a, input int n);
        i2c_start;
        send_byte(8'hD0, ackb); check("R1 dev ack", ackb, 1);
        send_byte({2'b00, a}, ackb); check("R2 waddr ack", ackb, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ackb); check("R3 data ack", ackb, 1);
        end
        i2c_stop;
    endtask

    task automatic read_seq(input logic use_addr, input logic [5:0] a, input int n);
        if (use_addr) begin
            i2c_start;
            send_byte(8'hD0, ackb); check("R1 dev ack", ackb, 1);
            send_byte({2'b00, a}, ackb); check("R2 waddr ack", ackb, 1);
        end
        i2c_start;
        send_byte(8'hD1, ackb); check("R4 read ack", ackb, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        i2c_stop;
    endtask

    task automatic pulse_tick(input logic [63:0] v);
        @(negedge clk); time_val = v; time_tick = 1'b1;
        @(negedge clk); time_tick = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(negedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v1, v2, v3;
        int          tc;
        w(5); rst_n = 1'b1; w(3);
        // reset state: SDA released, no time-set pulse, storage cleared
        check("R1 reset sda_oe", sda_oe, 0);
        check("R10 reset tset_valid", tset_valid, 0);
        read_seq(1, 6'h30, 1);
        check("R3 reset ram", rbuf[0], 8'h00);

        // vector table: single write then random read back
        for (int k = 0; k < 6; k++) begin
            tc = tset_cnt;
            wbuf[0] = VEC[k][7:0];
            write_seq(VEC[k][13:8], 1);
            read_seq(1, VEC[k][13:8], 1);
            check("R4 readback", rbuf[0], VEC[k][7:0]);
            if (VEC[k][13:8] < 6'd8) begin
                check("R10 tset count", tset_cnt - tc, 1);
                check("R10 tset addr", tset_last_a, VEC[k][10:8]);
                check("R10 tset data", tset_last_d, VEC[k][7:0]);
            end else begin
                check("R10 no tset for ram", tset_cnt - tc, 0);
            end
        end

        // R1: foreign address is ignored until next START
        w(4); oe_seen = 1'b0;
        i2c_start;
        send_byte(8'hA0, ackb); check("R1 foreign no ack", ackb, 0);
        send_byte(8'h08, ackb); check("R1 foreign ignored", ackb, 0);
        send_byte(8'h77, ackb); check("R1 foreign ignored", ackb, 0);
        i2c_stop;
        check("R1 sda never driven", oe_seen, 0);
        read_seq(1, 6'h08, 1);
        check("R1 ram untouched", rbuf[0], 8'hA5);

        // R3: pointer wraps from 3Fh to 00h
        tc = tset_cnt;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_seq(6'h3E, 3);
        read_seq(1, 6'h3E, 3);
        check("R3 wrap b0", rbuf[0], 8'h11);
        check("R3 wrap b1", rbuf[1], 8'h22);
        check("R3 wrap b2", rbuf[2], 8'h33);
        check("R10 wrap tset count", tset_cnt - tc, 1);
        check("R10 wrap tset addr", tset_last_a, 3'd0);

        // R5/R6: NACK keeps pointer; current-address read resumes there
        wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63;
        write_seq(6'h10, 3);
        read_seq(1, 6'h10, 1);
        check("R5 first byte", rbuf[0], 8'h61);
        read_seq(0, 6'h00, 1);
        check("R6 current read after nack", rbuf[0], 8'h61);
        read_seq(1, 6'h10, 2);
        check("R5 seq b0", rbuf[0], 8'h61);
        check("R5 seq b1", rbuf[1], 8'h62);
        read_seq(0, 6'h00, 2);
        check("R6 current read b0", rbuf[0], 8'h62);
        check("R6 current read b1", rbuf[1], 8'h63);

        // R7: strobe while idle updates clock bytes
        v1 = 64'h8877_6655_4433_2211;
        pulse_tick(v1); w(4);
        read_seq(1, 6'h00, 8);
        for (int i = 0; i < 8; i++) check("R7 snapshot byte", rbuf[i], v1[i*8 +: 8]);

        // R8 then R9 by STOP: strobe during freeze is held, applied at STOP
        v2 = 64'hF0E1_D2C3_B4A5_9687;
        i2c_start;
        send_byte(8'hD0, ackb); check("R1 dev ack", ackb, 1);
        send_byte(8'h02, ackb); check("R2 waddr ack", ackb, 1);
        pulse_tick(v2); w(4);
        i2c_start;
        send_byte(8'hD0, ackb); check("R1 dev ack", ackb, 1);
        send_byte(8'h00, ackb); check("R2 waddr ack", ackb, 1);
        i2c_start;
        send_byte(8'hD1, ackb); check("R4 read ack", ackb, 1);
        for (int i = 0; i < 4; i++) recv_byte(i != 3, rbuf[i]);
        i2c_stop;
        for (int i = 0; i < 4; i++) check("R8 frozen byte", rbuf[i], v1[i*8 +: 8]);
        read_seq(1, 6'h00, 8);
        for (int i = 0; i < 8; i++) check("R9 applied at stop", rbuf[i], v2[i*8 +: 8]);

        // R9 by leaving range: pointer 07h -> 08h releases the freeze
        v3 = 64'h0123_4567_89AB_CDEF;
        i2c_start;
        send_byte(8'hD0, ackb); check("R1 dev ack", ackb, 1);
        send_byte(8'h07, ackb); check("R2 waddr ack", ackb, 1);
        pulse_tick(v3); w(4);
        i2c_start;
        send_byte(8'hD1, ackb); check("R4 read ack", ackb, 1);
        recv_byte(1'b1, rbuf[0]);
        recv_byte(1'b0, rbuf[1]);
        check("R8 frozen byte 7", rbuf[0], v2[63:56]);
        check("R5 next byte 08h", rbuf[1], 8'hA5);
        i2c_start;
        send_byte(8'hD0, ackb); check("R1 dev ack", ackb, 1);
        send_byte(8'h00, ackb); check("R2 waddr ack", ackb, 1);
        i2c_start;
        send_byte(8'hD1, ackb); check("R4 read ack", ackb, 1);
        recv_byte(1'b0, rbuf[0]);
        i2c_stop;
        check("R9 applied on leaving range", rbuf[0], v3[7:0]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule